// File: doc/BRIEF.md
# Low-Power Compare-Match Timer

This block is a memory-mapped 16-bit up-counter that keeps time while the processor sleeps. A slow, always-on clock reaches it as a one-cycle enable pulse, `tick_in`, on the system clock. A power-of-two prescaler divides that pulse stream, and each divided tick advances the counter. The counter runs up to an auto-reload value and wraps to zero. Each time the count equals a compare value on a tick, a flag is raised, and that flag can drive the interrupt/wake-up output.

Software turns the block on first. It then loads the compare and auto-reload values and starts counting in either continuous or single-shot mode. Before each sleep it re-arms the compare value relative to the live count. Flags are cleared by writing ones to a separate clear register. Two optional behaviours are available: a read of the counter can return the counter to zero, and a control bit can zero it directly.

Top module: `lpt_timer`

## Requirements
- R1: Byte offsets are 0x00 status, 0x04 clear, 0x08 interrupt enable, 0x0C configuration, 0x10 control, 0x14 compare, 0x18 auto-reload and 0x1C counter. After reset, auto-reload reads 0x0000FFFF and every other register reads 0. The clear register always reads 0.
- R2: The prescaler exponent sits in configuration bits 11:9. It can be written only while the control enable bit (bit 0) is 0. A write while enabled leaves the field unchanged.
- R3: Writes to compare or auto-reload are ignored while enable is 0. Once an accepted write has been taken, the next clock edge sets the matching write-complete flag: status bit 3 for compare, bit 4 for auto-reload.
- R4: With exponent P, the counter advances once per 2^P `tick_in` pulses. The prescaler is held at its start while enable is 0.
- R5: Writing control bit 2 starts continuous counting. A tick taken while the count equals the auto-reload value sets it to 0 and sets status bit 1.
- R6: Writing control bit 1 starts single-shot counting. The counter stops after the wrap to 0, and later ticks leave it at 0.
- R7: A tick taken while the count equals the compare value sets status bit 0.
- R8: Writing 1 to a bit of the clear register clears that status bit, and writing 0 has no effect. When a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when some status bit and its interrupt-enable bit are both 1.
- R10: Writing control bit 3 zeroes the count. When control bit 4 is 1, a read of the counter (`bus_re` at 0x1C) returns the live count and then zeroes it.
- R11: Clearing enable stops the counter. Ticks then leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle pulse per slow-clock period |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (used for reset-after-read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt / wake-up request |

## Verification
Two things can land in the same clock cycle: a compare-match flag being set by a counter tick, and software clearing that same flag through the clear register. The bench stops the counter one tick short of the compare value. On a single edge it then drives the last `tick_in` pulse together with a clear-register write of bit 0. The status register must still show bit 0 afterwards. A clear on its own must then remove the flag, while a write of zeros to the clear register must leave it in place.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NFLAG  = 7;

  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ARR  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h1C;

  // flag positions, shared by status, clear and enable
  localparam int FL_CMP_HIT = 0;
  localparam int FL_ARR_HIT = 1;
  localparam int FL_CMP_WC  = 3;
  localparam int FL_ARR_WC  = 4;

  // control bits
  localparam int CT_EN     = 0;
  localparam int CT_SINGLE = 1;
  localparam int CT_CONT   = 2;
  localparam int CT_ZERO   = 3;
  localparam int CT_RAR    = 4;

  localparam int PSC_LSB = 9;

  // low-order ones mask for a divide-by-2^l prescaler
  function automatic logic [31:0] lpt_div_mask(input logic [4:0] l);
    return (32'd1 << l) - 32'd1;
  endfunction
endpackage

// File: rtl/lpt_prescale.sv
module lpt_prescale #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick_in,
  input  logic [PSC_W-1:0] log2_div,
  output logic             tick_out
);
  import lpt_pkg::*;
  localparam int STG_W = (1 << PSC_W) - 1;

  logic [STG_W-1:0] stage;
  logic [31:0]      mask_full;
  logic [STG_W-1:0] mask;
  logic             at_top;

  assign mask_full = lpt_div_mask(5'(log2_div));
  assign mask      = mask_full[STG_W-1:0];
  assign at_top    = (stage == mask);
  assign tick_out  = en && tick_in && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage <= '0;
    else if (!en)     stage <= '0;
    else if (tick_in) stage <= at_top ? '0 : stage + 1'b1;
  end

  a_r4_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> (en && tick_in));
  a_r4_stage_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (stage == '0));
endmodule

// File: rtl/lpt_count.sv
module lpt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             go_cont,
  input  logic             go_single,
  input  logic             cnt_zero,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] cnt,
  output logic             cmp_hit,
  output logic             arr_hit
);
  logic running, single;
  logic step;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] top);
    return (c == top) ? '0 : c + 1'b1;
  endfunction

  assign step    = en && running && tick;
  assign arr_hit = step && (cnt == reload);
  assign cmp_hit = step && (cnt == compare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      single  <= 1'b0;
    end else if (!en) begin
      running <= 1'b0;
    end else begin
      if (cnt_zero)  cnt <= '0;
      else if (step) cnt <= next_count(cnt, reload);
      if (arr_hit && single) running <= 1'b0;
      if (go_cont) begin
        running <= 1'b1;
        single  <= 1'b0;
      end
      if (go_single) begin
        running <= 1'b1;
        single  <= 1'b1;
      end
    end
  end

  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    arr_hit |=> (cnt == '0));
  a_r6_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_hit && single && !go_cont && !go_single) |=> !running);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [lpt_pkg::ADDR_W-1:0] bus_addr,
  input  logic                      bus_we,
  input  logic                      bus_re,
  input  logic [lpt_pkg::DATA_W-1:0] bus_wdata,
  output logic [lpt_pkg::DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]          cnt,
  input  logic                      cmp_hit,
  input  logic                      arr_hit,
  output logic                      en,
  output logic [PSC_W-1:0]          psc,
  output logic [CNT_W-1:0]          cmp_val,
  output logic [CNT_W-1:0]          arr_val,
  output logic                      go_cont,
  output logic                      go_single,
  output logic                      cnt_zero,
  output logic                      irq
);
  import lpt_pkg::*;

  logic [NFLAG-1:0] stat, ien, set_v, clr_v;
  logic             rar;
  logic             cmp_wr_ok, arr_wr_ok, pend_cmp, pend_arr;
  logic             wr_ctrl;

  assign wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
  assign cmp_wr_ok = bus_we && (bus_addr == OFS_CMP) && en;
  assign arr_wr_ok = bus_we && (bus_addr == OFS_ARR) && en;
  assign go_cont   = wr_ctrl && bus_wdata[CT_CONT];
  assign go_single = wr_ctrl && bus_wdata[CT_SINGLE];
  assign cnt_zero  = (wr_ctrl && bus_wdata[CT_ZERO]) ||
                     (bus_re && (bus_addr == OFS_CNT) && rar);

  always_comb begin
    set_v             = '0;
    set_v[FL_CMP_HIT] = cmp_hit;
    set_v[FL_ARR_HIT] = arr_hit;
    set_v[FL_CMP_WC]  = pend_cmp;
    set_v[FL_ARR_WC]  = pend_arr;
    clr_v = (bus_we && (bus_addr == OFS_CLR)) ? bus_wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat     <= '0;
      ien      <= '0;
      en       <= 1'b0;
      rar      <= 1'b0;
      psc      <= '0;
      cmp_val  <= '0;
      arr_val  <= '1;
      pend_cmp <= 1'b0;
      pend_arr <= 1'b0;
    end else begin
      stat     <= (stat & ~clr_v) | set_v;
      pend_cmp <= cmp_wr_ok;
      pend_arr <= arr_wr_ok;
      if (bus_we && bus_addr == OFS_IEN) ien <= bus_wdata[NFLAG-1:0];
      if (bus_we && bus_addr == OFS_CFG && !en) psc <= bus_wdata[PSC_LSB +: PSC_W];
      if (wr_ctrl) begin
        en  <= bus_wdata[CT_EN];
        rar <= bus_wdata[CT_RAR];
      end
      if (cmp_wr_ok) cmp_val <= bus_wdata[CNT_W-1:0];
      if (arr_wr_ok) arr_val <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_STAT: bus_rdata[NFLAG-1:0] = stat;
      OFS_IEN:  bus_rdata[NFLAG-1:0] = ien;
      OFS_CFG:  bus_rdata[PSC_LSB +: PSC_W] = psc;
      OFS_CTRL: begin
        bus_rdata[CT_EN]  = en;
        bus_rdata[CT_RAR] = rar;
      end
      OFS_CMP:  bus_rdata[CNT_W-1:0] = cmp_val;
      OFS_ARR:  bus_rdata[CNT_W-1:0] = arr_val;
      OFS_CNT:  bus_rdata[CNT_W-1:0] = cnt;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = |(stat & ien);

  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(psc));
  a_r3_cmp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CMP && !en) |=> $stable(cmp_val));
  a_r3_cmp_complete: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_ok |=> ##1 stat[FL_CMP_WC]);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> stat[FL_CMP_HIT]);
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0));
endmodule

// File: rtl/lpt_timer.sv
module lpt_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic             en, go_cont, go_single, cnt_zero;
  logic             tick, cmp_hit, arr_hit;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cmp_val, arr_val, cnt;

  lpt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .cmp_hit(cmp_hit), .arr_hit(arr_hit), .en(en), .psc(psc),
    .cmp_val(cmp_val), .arr_val(arr_val), .go_cont(go_cont),
    .go_single(go_single), .cnt_zero(cnt_zero), .irq(irq));

  lpt_prescale #(.PSC_W(PSC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .tick_in(tick_in),
    .log2_div(psc), .tick_out(tick));

  lpt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .go_cont(go_cont),
    .go_single(go_single), .cnt_zero(cnt_zero), .reload(arr_val),
    .compare(cmp_val), .cnt(cnt), .cmp_hit(cmp_hit), .arr_hit(arr_hit));
endmodule

// File: tb/lpt_timer_bench.sv
`timescale 1ns/1ps
module lpt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  lpt_timer u_lpt_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // {is_read, offset, data}
  localparam int NV = 18;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0000_0000},   // R1 status reset
    {1'b1, 8'h18, 32'h0000_FFFF},   // R1 reload reset
    {1'b1, 8'h04, 32'h0000_0000},   // R1 clear reads 0
    {1'b0, 8'h14, 32'h0000_1234},   // R3 compare write while off
    {1'b1, 8'h14, 32'h0000_0000},   // R3 ignored
    {1'b0, 8'h0C, 32'h0000_0400},   // R2 exponent 2
    {1'b1, 8'h0C, 32'h0000_0400},   // R2
    {1'b0, 8'h10, 32'h0000_0001},   // enable
    {1'b0, 8'h0C, 32'h0000_0200},   // R2 locked
    {1'b1, 8'h0C, 32'h0000_0400},   // R2
    {1'b0, 8'h14, 32'h0000_0005},   // R3 compare = 5
    {1'b1, 8'h00, 32'h0000_0008},   // R3 compare write-complete
    {1'b0, 8'h18, 32'h0000_0009},   // R3 reload = 9
    {1'b1, 8'h00, 32'h0000_0018},   // R3 both write-complete
    {1'b0, 8'h04, 32'h0000_0008},   // R8 clear bit 3 only
    {1'b1, 8'h00, 32'h0000_0010},   // R8
    {1'b0, 8'h04, 32'h0000_007F},   // R8 clear all
    {1'b0, 8'h08, 32'h0000_0003}    // R9 enable both match irqs
  };
  localparam string TAG [NV] = '{"R1","R1","R1","R3","R3","R2","R2","R2","R2",
                                 "R2","R3","R3","R3","R3","R8","R8","R8","R9"};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic re, output logic [31:0] d);
    bus_addr = a; bus_re = re;
    #2;
    d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, 1'b0, d);
    check(req, d, exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_in = 1'b1;
      repeat (n) @(negedge clk);
      tick_in = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) rd_chk(TAG[i], VEC[i][39:32], VEC[i][31:0]);
      else            wr(VEC[i][39:32], VEC[i][31:0]);
    end

    // R4/R5: divide by 4, continuous
    wr(8'h10, 32'h5);
    ticks(11);
    rd_chk("R4 count after 11 pulses", 8'h1C, 32'd2);
    ticks(1);
    rd_chk("R4 count after 12 pulses", 8'h1C, 32'd3);
    ticks(8);
    rd_chk("R7 no match before compare", 8'h00, 32'h0);
    ticks(4);
    rd_chk("R7 compare match flag", 8'h00, 32'h1);
    check("R9 irq on match", {31'b0, irq}, 32'h1);
    ticks(12);
    rd_chk("R5 at reload", 8'h1C, 32'd9);
    ticks(4);
    rd_chk("R5 wrapped to zero", 8'h1C, 32'd0);
    rd_chk("R5 reload flag", 8'h00, 32'h3);
    ticks(4);
    rd_chk("R5 keeps running", 8'h1C, 32'd1);

    // R11: disable freezes
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'h0);
    ticks(5);
    rd_chk("R11 frozen when off", 8'h1C, 32'd1);
    wr(8'h04, 32'h7F);
    check("R9 irq drops with flags", {31'b0, irq}, 32'h0);

    // R10/R6: zero then single shot at divide-by-1
    wr(8'h10, 32'h1);
    wr(8'h10, 32'h9);
    rd_chk("R10 counter zeroed", 8'h1C, 32'd0);
    wr(8'h10, 32'h3);
    ticks(9);
    rd_chk("R6 single reaches reload", 8'h1C, 32'd9);
    ticks(1);
    rd_chk("R6 single wrapped", 8'h1C, 32'd0);
    rd_chk("R6 flags after single", 8'h00, 32'h3);
    ticks(5);
    rd_chk("R6 single stopped", 8'h1C, 32'd0);

    // R10: reset-after-read
    wr(8'h10, 32'h15);
    ticks(3);
    rd(8'h1C, 1'b1, d);
    check("R10 read returns live count", d, 32'd3);
    rd(8'h1C, 1'b1, d);
    check("R10 count zeroed by read", d, 32'd0);

    // R8: set and clear in the same cycle
    wr(8'h04, 32'h7F);
    ticks(5);
    rd_chk("R8 no flag before hit", 8'h00, 32'h0);
    bus_addr = 8'h04; bus_wdata = 32'h1; bus_we = 1'b1; tick_in = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_in = 1'b0;
    rd_chk("R8 set wins over clear", 8'h00, 32'h1);
    wr(8'h04, 32'h0);
    rd_chk("R8 zero write no effect", 8'h00, 32'h1);
    wr(8'h04, 32'h1);
    rd_chk("R8 one write clears", 8'h00, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule